// File: doc/BRIEF.md
# Reset control register bank

This block holds the reset state of a set of on-chip peripherals and lets software change it through a small register port that follows the APB access pattern. Two 32-bit control words drive 64 reset lines, with a 1 meaning the line is held in reset. Each word has its own address for asserting resets and a second address, 4 bytes higher, for releasing them. Software can therefore assert or release one peripheral without touching the others and without first reading the word.

A third register holds one more reset line in its bit 0. This line is active low, and the register is an ordinary read/write location. Software changes it by reading it, editing bit 0 and writing it back. Every reset output comes straight from a flop, so address decoding cannot put a glitch on a reset line.

The port never stalls. A write is captured on the clock edge where the select and enable strobes are both high, and it shows at the reset outputs right after that edge. Reads are answered in the same access phase.

Top module: `rst_ctl_bank`

## Requirements
- R1: After power-on reset, every line of word A (offset 0x200) is held, giving 0xFFFF_FFFF. Every assigned line of word B (offset 0x220) is held, giving 0xFFFF_F7FF. The active-low line `rst_aux_n` is 0, which also means held.
- R2: A write to 0x200 or 0x220 sets every bit of that word whose data bit is 1 and leaves the bits written as 0 unchanged.
- R3: A write to 0x204 or 0x224 clears every bit of word A or word B, respectively, whose data bit is 1, and leaves the bits written as 0 unchanged.
- R4: A read of 0x200 or 0x220 returns the present state of that word, with a 1 meaning the line is held.
- R5: Offset 0x908 is a plain read/write register. Only bit 0 is stored, and it drives `rst_aux_n` directly (0 holds the line, 1 releases it). Bits 31..1 read as 0, and writes to them are ignored.
- R6: Bit 11 of word B is unassigned. It always reads as 0, drives 0, and ignores both set and clear writes.
- R7: A read of 0x204, 0x224 or any undecoded offset returns 0. A write to an undecoded offset changes no output.
- R8: A write takes effect only on a clock edge with `psel`, `penable` and `pwrite` all high. Its result appears at the outputs right after that edge and not before. A setup phase alone (`penable` low) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high on a read |
| rst_word_a | output | 32 | Reset lines of word A, 1 = held |
| rst_word_b | output | 32 | Reset lines of word B, 1 = held, bit 11 always 0 |
| rst_aux_n | output | 1 | Auxiliary reset line, active low |

## Verification
A corrupted bit in either control word shows at its reset output pin as soon as the corruption happens. It also shows on the next read of the primary offset, so every check compares the pins and the read-back value. A fault in the set or clear decode shows right after the access edge of the faulty write: a wrong bit toggles, or the bits written as 0 do not stay put. Those bits are always given values that are known to differ. A write that lands early or without the enable phase is caught by sampling the outputs in the access phase before the edge, and after a setup-only phase.

// File: rtl/rst_ctl_bank.sv
module rst_ctl_bank #(
  parameter int              ADDR_W    = 12,
  parameter int              DW        = 32,
  parameter logic [11:0]     OFS_A     = 12'h200,
  parameter logic [11:0]     OFS_B     = 12'h220,
  parameter logic [11:0]     CLR_STEP  = 12'h004,
  parameter logic [11:0]     OFS_AUX   = 12'h908,
  parameter logic [31:0]     MASK_A    = 32'hFFFF_FFFF,
  parameter logic [31:0]     MASK_B    = 32'hFFFF_F7FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  output logic [DW-1:0]     prdata,
  output logic [DW-1:0]     rst_word_a,
  output logic [DW-1:0]     rst_word_b,
  output logic              rst_aux_n
);

  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_A);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_A + CLR_STEP);
  localparam logic [ADDR_W-1:0] B_SET = ADDR_W'(OFS_B);
  localparam logic [ADDR_W-1:0] B_CLR = ADDR_W'(OFS_B + CLR_STEP);
  localparam logic [ADDR_W-1:0] AUX   = ADDR_W'(OFS_AUX);
  localparam logic [DW-1:0]     VA    = DW'(MASK_A);
  localparam logic [DW-1:0]     VB    = DW'(MASK_B);

  logic [DW-1:0] word_a, word_b;
  logic          aux;

  wire wr = psel & penable & pwrite;
  wire rd = psel & ~pwrite;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_a <= VA;
      word_b <= VB;
      aux    <= 1'b0;
    end else if (wr) begin
      case (paddr)
        A_SET:   word_a <= (word_a | pwdata) & VA;
        A_CLR:   word_a <= word_a & ~pwdata & VA;
        B_SET:   word_b <= (word_b | pwdata) & VB;
        B_CLR:   word_b <= word_b & ~pwdata & VB;
        AUX:     aux    <= pwdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    prdata = '0;
    if (rd) begin
      case (paddr)
        A_SET:   prdata = word_a;
        B_SET:   prdata = word_b;
        AUX:     prdata = {{(DW-1){1'b0}}, aux};
        default: prdata = '0;
      endcase
    end
  end

  assign rst_word_a = word_a;
  assign rst_word_b = word_b;
  assign rst_aux_n  = aux;

  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_word_b & ~VB) == '0); // R6

  AST_SET_A: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == A_SET) |=> ((rst_word_a & $past(pwdata)) == ($past(pwdata) & VA))
                              && ((rst_word_a & ~$past(pwdata)) == ($past(rst_word_a) & ~$past(pwdata)))); // R2

  AST_CLR_B: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == B_CLR) |=> ((rst_word_b & $past(pwdata)) == '0)
                              && ((rst_word_b & ~$past(pwdata)) == ($past(rst_word_b) & ~$past(pwdata)))); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(rst_word_a) && $stable(rst_word_b) && $stable(rst_aux_n)); // R8

  AST_ALIAS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (paddr == A_CLR || paddr == B_CLR)) |-> prdata == '0); // R7

  AST_AUX_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && paddr == AUX) |-> prdata[DW-1:1] == '0); // R5

endmodule

// File: tb/tb_rst_ctl_bank.sv
module tb_rst_ctl_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, rst_word_a, rst_word_b;
  logic        rst_aux_n;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit ended = 0;

  rst_ctl_bank dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .rst_word_a(rst_word_a), .rst_word_b(rst_word_b), .rst_aux_n(rst_aux_n)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      finish_run();
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 word A", rst_word_a, 32'hFFFF_FFFF);
    chk("R1 word B", rst_word_b, 32'hFFFF_F7FF);
    chk("R1 aux", {31'b0, rst_aux_n}, 32'h0);
    rd(12'h200, v); chk("R4 read A", v, 32'hFFFF_FFFF);
    rd(12'h220, v); chk("R4 read B", v, 32'hFFFF_F7FF);
    rd(12'h908, v); chk("R5 read aux", v, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(12'h204, 32'h0000_FFFF);
    chk("R3 clear A", rst_word_a, 32'hFFFF_0000);
    chk("R3 B untouched", rst_word_b, 32'hFFFF_F7FF);
    rd(12'h200, v); chk("R4 read A", v, 32'hFFFF_0000);
    wr(12'h224, 32'hFFFF_FFFF);
    chk("R3 clear B", rst_word_b, 32'h0);
    chk("R3 A untouched", rst_word_a, 32'hFFFF_0000);
  endtask

  task automatic t_set();
    logic [31:0] v;
    wr(12'h220, 32'h0000_0F0F);
    chk("R2 R6 set B", rst_word_b, 32'h0000_070F);
    rd(12'h220, v); chk("R6 read B", v, 32'h0000_070F);
    wr(12'h200, 32'h0000_0005);
    chk("R2 set A", rst_word_a, 32'hFFFF_0005);
    wr(12'h224, 32'h0000_0001);
    chk("R3 partial clear B", rst_word_b, 32'h0000_070E);
  endtask

  task automatic t_aux();
    logic [31:0] v;
    rd(12'h908, v);
    wr(12'h908, v | 32'hFFFF_FFFF);
    chk("R5 release aux", {31'b0, rst_aux_n}, 32'h1);
    rd(12'h908, v); chk("R5 read aux", v, 32'h1);
    wr(12'h908, v & ~32'h1);
    chk("R5 hold aux", {31'b0, rst_aux_n}, 32'h0);
    chk("R5 A untouched", rst_word_a, 32'hFFFF_0005);
  endtask

  task automatic t_undecoded();
    logic [31:0] v;
    rd(12'h204, v); chk("R7 alias A read", v, 32'h0);
    rd(12'h224, v); chk("R7 alias B read", v, 32'h0);
    rd(12'h300, v); chk("R7 undecoded read", v, 32'h0);
    wr(12'h300, 32'hFFFF_FFFF);
    wr(12'h210, 32'hFFFF_FFFF);
    chk("R7 A after stray write", rst_word_a, 32'hFFFF_0005);
    chk("R7 B after stray write", rst_word_b, 32'h0000_070E);
    chk("R7 aux after stray write", {31'b0, rst_aux_n}, 32'h0);
  endtask

  task automatic t_timing();
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = 12'h200; pwdata = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R8 setup only", rst_word_a, 32'hFFFF_0005);
    psel = 0; pwrite = 0;
    @(negedge clk);
    chk("R8 no enable", rst_word_a, 32'hFFFF_0005);
    psel = 1; pwrite = 1; paddr = 12'h204; pwdata = 32'h0000_0004;
    @(negedge clk);
    penable = 1;
    #1 chk("R8 before edge", rst_word_a, 32'hFFFF_0005);
    @(posedge clk); #1;
    chk("R8 after edge", rst_word_a, 32'hFFFF_0001);
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_clear();
    t_set();
    t_aux();
    t_undecoded();
    t_timing();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule